// File: doc/BRIEF.md
# Piecewise-Linear Sensor Code to Temperature Converter

This block turns a raw reading from an on-die thermal sensor into a signed temperature in millidegrees Celsius. A request carries a raw code and a direction select. The converter keeps only the low bits that the selected calibration table uses. It checks that the code lies inside the span the table covers, and then runs a binary search, one probe per clock, for the table segment that holds the code. Finally it interpolates linearly between the two ends of that segment, using an iterative restoring divider that truncates toward zero.

Each instance carries two calibration tables as parameters. In one table the codes fall as the temperature rises; in the other the codes rise with temperature. Every table has one entry per calibration point. Entry 0 is a guard entry: it holds the all-ones mask value in the falling table and zero in the rising table. Entry 0 and entry 1 both stand for the lowest temperature, and each later entry is one calibration step (5000 m°C by default) warmer than the entry before it. The block takes one request at a time and returns exactly one result for each request: either a temperature, or an error flag with a zero temperature.

Top module: `plc_code2temp`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Only the low bits of `in_code` are used: `in_code & 0xfff` in falling mode (`in_rising`=0) and `in_code & 0x3ff` in rising mode (`in_rising`=1). Any bits above the mask do not change the result.
- R3: In falling mode (codes e[0] > e[1] > ... > e[N-1]), a code c with e[s] <= c < e[s-1] gives t[s-1] + floor((t[s]-t[s-1]) * (e[s-1]-c) / (e[s-1]-e[s])). Here t[0] = t[1] = T_MIN, and t[i] = T_MIN + (i-1)*STEP for i >= 1.
- R4: In rising mode (codes e[0] < e[1] < ... < e[N-1]), a code c with e[s-1] <= c < e[s] gives t[s-1] + floor((t[s]-t[s-1]) * (c-e[s-1]) / (e[s]-e[s-1])).
- R5: In falling mode, a masked code below e[N-1], or equal to or above e[0], is rejected. A rejection returns `out_err`=1 and `out_temp`=0.
- R6: In rising mode, a masked code below e[1], or equal to or above e[N-1], is rejected in the same way.
- R7: In falling mode, every code in [e[1], e[0]) returns exactly T_MIN, because the guard segment is flat.
- R8: A code equal to a breakpoint e[i] of a non-guard segment returns exactly t[i].
- R9: `in_ready` is high only when the block is idle. A request is accepted when `in_valid` and `in_ready` are both high. While busy, `in_ready` is low and `in_valid` is ignored. Each accepted request gives exactly one single-cycle `out_valid` pulse.
- R10: The result appears no more than 4 + clog2(ENTRIES) + clog2(STEP+1) cycles after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_ready | output | 1 | High when a request can be accepted |
| in_rising | input | 1 | 1: rising-code table, 0: falling-code table |
| in_code | input | RAW_W | Raw sensor reading |
| out_valid | output | 1 | One-cycle result strobe |
| out_err | output | 1 | Reading rejected (temperature forced to 0) |
| out_temp | output | TEMP_W | Signed temperature in millidegrees Celsius |

## Verification
A search that moves in the wrong direction, or stops one probe early, shows up as a rejected reading or as a temperature from the neighbouring segment. The bench therefore runs every code of a small ten-entry table in both modes and compares each result against arithmetic done in the bench. A fault in the divider's remainder or its bit index corrupts the fraction, so every code inside a segment exposes it at the next result pulse, which comes at most about twenty cycles after the request. Faults in the handshake show up as a missing or repeated result, or as a second request being taken while the block is busy. The bench catches these within the same transaction through pulse counting and a cycle bound.

// File: rtl/plc_temp_pkg.sv
package plc_temp_pkg;

  localparam int DEF_ENTRIES = 35;
  localparam int DEF_CODE_W  = 12;

  typedef enum logic [1:0] {
    TOP_IDLE,
    TOP_SEARCH,
    TOP_LOAD,
    TOP_DIV
  } top_state_e;

  typedef enum logic [1:0] {
    SR_IDLE,
    SR_CHECK,
    SR_STEP
  } srch_state_e;

  // Falling-code default: guard entry at full scale, then a gently curved slope.
  function automatic logic [DEF_ENTRIES*DEF_CODE_W-1:0] default_falling_table();
    logic [DEF_ENTRIES*DEF_CODE_W-1:0] tab;
    tab = '0;
    for (int i = 0; i < DEF_ENTRIES; i++) begin
      int val;
      if (i == 0) val = (1 << DEF_CODE_W) - 1;
      else        val = 3800 - 9 * (i - 1) - ((i - 1) * (i - 1)) / 8;
      tab[i*DEF_CODE_W +: DEF_CODE_W] = DEF_CODE_W'(val);
    end
    return tab;
  endfunction

  // Rising-code default: guard entry at zero, then a slightly uneven slope.
  function automatic logic [DEF_ENTRIES*DEF_CODE_W-1:0] default_rising_table();
    logic [DEF_ENTRIES*DEF_CODE_W-1:0] tab;
    tab = '0;
    for (int i = 0; i < DEF_ENTRIES; i++) begin
      int val;
      if (i == 0) val = 0;
      else        val = 100 + 2 * (i - 1) + (i - 1) / 4;
      tab[i*DEF_CODE_W +: DEF_CODE_W] = DEF_CODE_W'(val);
    end
    return tab;
  endfunction

endpackage

// File: rtl/plc_cal_rom.sv
module plc_cal_rom #(
  parameter int ENTRIES = 35,
  parameter int CODE_W  = 12,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter logic [ENTRIES*CODE_W-1:0] FALL_TAB = '0,
  parameter logic [ENTRIES*CODE_W-1:0] RISE_TAB = '0
) (
  input  logic              rising,
  input  logic [IDX_W-1:0]  idx,
  output logic [CODE_W-1:0] cur,
  output logic [CODE_W-1:0] prev
);

  logic [CODE_W-1:0] fall_mem [ENTRIES];
  logic [CODE_W-1:0] rise_mem [ENTRIES];

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_unpack
    assign fall_mem[gi] = FALL_TAB[gi*CODE_W +: CODE_W];
    assign rise_mem[gi] = RISE_TAB[gi*CODE_W +: CODE_W];
  end

  logic [IDX_W-1:0] idx_prev;
  assign idx_prev = (idx == '0) ? '0 : idx - IDX_W'(1);

  always_comb begin
    if (rising) begin
      cur  = rise_mem[idx];
      prev = rise_mem[idx_prev];
    end else begin
      cur  = fall_mem[idx];
      prev = fall_mem[idx_prev];
    end
  end

endmodule

// File: rtl/plc_seg_search.sv
module plc_seg_search
  import plc_temp_pkg::*;
#(
  parameter int ENTRIES = 35,
  parameter int CODE_W  = 12,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rising,
  input  logic [CODE_W-1:0] code,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [CODE_W-1:0] cur,
  input  logic [CODE_W-1:0] prev,
  output logic              done,
  output logic              found,
  output logic [IDX_W-1:0]  seg
);

  localparam int LW = IDX_W + 1;
  localparam logic [LW-1:0]    LO_INIT  = LW'(1);
  localparam logic [LW-1:0]    HI_INIT  = LW'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] MID_INIT = IDX_W'(ENTRIES / 2);

  srch_state_e      state;
  logic [LW-1:0]    lo, hi;
  logic [IDX_W-1:0] mid;

  logic          hit, go_up;
  logic [LW-1:0] mid_w, nlo, nhi, nsum;

  // In CHECK the lower bound entry is probed: the last one for falling
  // tables, entry 1 for rising tables. Both reject when code < entry.
  always_comb begin
    if (state == SR_CHECK) rd_idx = rising ? IDX_W'(1) : IDX_W'(ENTRIES - 1);
    else                   rd_idx = mid;
  end

  always_comb begin
    mid_w = LW'(mid);
    if (rising) begin
      hit   = (code >= prev) && (code < cur);
      go_up = (code >= cur);
    end else begin
      hit   = (code >= cur) && (code < prev);
      go_up = (code < cur);
    end
    nlo  = go_up ? mid_w + LW'(1) : lo;
    nhi  = go_up ? hi : mid_w - LW'(1);
    nsum = nlo + nhi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SR_IDLE;
      lo    <= LO_INIT;
      hi    <= HI_INIT;
      mid   <= MID_INIT;
      done  <= 1'b0;
      found <= 1'b0;
      seg   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        SR_IDLE: begin
          if (start) state <= SR_CHECK;
        end
        SR_CHECK: begin
          if (code < cur) begin
            done  <= 1'b1;
            found <= 1'b0;
            state <= SR_IDLE;
          end else begin
            lo    <= LO_INIT;
            hi    <= HI_INIT;
            mid   <= MID_INIT;
            state <= SR_STEP;
          end
        end
        SR_STEP: begin
          if (hit) begin
            done  <= 1'b1;
            found <= 1'b1;
            seg   <= mid;
            state <= SR_IDLE;
          end else if (nlo > nhi) begin
            done  <= 1'b1;
            found <= 1'b0;
            state <= SR_IDLE;
          end else begin
            lo  <= nlo;
            hi  <= nhi;
            mid <= nsum[LW-1:1];
          end
        end
        default: state <= SR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/plc_div_iter.sv
module plc_div_iter #(
  parameter int NUM_W = 25,
  parameter int DEN_W = 12,
  parameter int QW    = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [QW-1:0]    quo
);

  localparam int BW = (QW > 1) ? $clog2(QW) : 1;

  logic [NUM_W-1:0] rem;
  logic [DEN_W-1:0] den_q;
  logic [BW-1:0]    bit_q;
  logic             active;
  logic [NUM_W-1:0] trial;

  // Quotient is known to fit in QW bits, so only QW restoring steps run.
  assign trial = NUM_W'(den_q) << bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem    <= '0;
      den_q  <= '0;
      bit_q  <= '0;
      active <= 1'b0;
      done   <= 1'b0;
      quo    <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem    <= num;
        den_q  <= den;
        bit_q  <= BW'(QW - 1);
        active <= 1'b1;
        quo    <= '0;
      end else if (active) begin
        if (rem >= trial) begin
          rem        <= rem - trial;
          quo[bit_q] <= 1'b1;
        end
        if (bit_q == '0) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          bit_q <= bit_q - BW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/plc_code2temp.sv
module plc_code2temp
  import plc_temp_pkg::*;
#(
  parameter int RAW_W   = 16,
  parameter int CODE_W  = DEF_CODE_W,
  parameter int ENTRIES = DEF_ENTRIES,
  parameter int TEMP_W  = 32,
  parameter int T_MIN   = -40000,
  parameter int STEP    = 5000,
  parameter logic [RAW_W-1:0] FALL_MASK = RAW_W'(16'h0fff),
  parameter logic [RAW_W-1:0] RISE_MASK = RAW_W'(16'h03ff),
  parameter logic [ENTRIES*CODE_W-1:0] FALL_TAB = default_falling_table(),
  parameter logic [ENTRIES*CODE_W-1:0] RISE_TAB = default_rising_table()
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_rising,
  input  logic [RAW_W-1:0]         in_code,
  output logic                     out_valid,
  output logic                     out_err,
  output logic signed [TEMP_W-1:0] out_temp
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int QW    = $clog2(STEP + 1);
  localparam int NUM_W = CODE_W + QW;

  top_state_e        state;
  logic              rising_q;
  logic [CODE_W-1:0] code_q;
  logic [TEMP_W-1:0] base_q;

  logic              accept;
  logic [CODE_W-1:0] masked;

  logic [IDX_W-1:0]  srch_idx, rom_idx, srch_seg;
  logic [CODE_W-1:0] rom_cur, rom_prev;
  logic              srch_done, srch_found;

  logic [CODE_W-1:0] diff_c, den_c;
  logic [NUM_W-1:0]  num_c;
  logic [IDX_W-1:0]  seg_steps;
  logic [TEMP_W-1:0] base_c;
  logic              div_start, div_done;
  logic [QW-1:0]     div_quo;

  assign in_ready = (state == TOP_IDLE);
  assign accept   = in_valid && in_ready;

  always_comb begin
    if (in_rising) masked = CODE_W'(in_code & RISE_MASK);
    else           masked = CODE_W'(in_code & FALL_MASK);
  end

  assign rom_idx = (state == TOP_LOAD) ? srch_seg : srch_idx;

  plc_cal_rom #(
    .ENTRIES (ENTRIES),
    .CODE_W  (CODE_W),
    .IDX_W   (IDX_W),
    .FALL_TAB(FALL_TAB),
    .RISE_TAB(RISE_TAB)
  ) u_rom (
    .rising(rising_q),
    .idx   (rom_idx),
    .cur   (rom_cur),
    .prev  (rom_prev)
  );

  plc_seg_search #(
    .ENTRIES(ENTRIES),
    .CODE_W (CODE_W),
    .IDX_W  (IDX_W)
  ) u_search (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .rising(rising_q),
    .code  (code_q),
    .rd_idx(srch_idx),
    .cur   (rom_cur),
    .prev  (rom_prev),
    .done  (srch_done),
    .found (srch_found),
    .seg   (srch_seg)
  );

  // Segment arithmetic, evaluated while the ROM is pointed at the found segment.
  always_comb begin
    if (rising_q) begin
      diff_c = code_q - rom_prev;
      den_c  = rom_cur - rom_prev;
    end else begin
      diff_c = rom_prev - code_q;
      den_c  = rom_prev - rom_cur;
    end
    if (srch_seg == IDX_W'(1)) num_c = '0;
    else                       num_c = NUM_W'(STEP) * NUM_W'(diff_c);
    seg_steps = (srch_seg >= IDX_W'(2)) ? srch_seg - IDX_W'(2) : '0;
    base_c    = TEMP_W'(T_MIN + STEP * int'(seg_steps));
  end

  assign div_start = (state == TOP_LOAD);

  plc_div_iter #(
    .NUM_W(NUM_W),
    .DEN_W(CODE_W),
    .QW   (QW)
  ) u_div (
    .clk  (clk),
    .rst  (rst),
    .start(div_start),
    .num  (num_c),
    .den  (den_c),
    .done (div_done),
    .quo  (div_quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= TOP_IDLE;
      rising_q  <= 1'b0;
      code_q    <= '0;
      base_q    <= '0;
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_temp  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        TOP_IDLE: begin
          if (accept) begin
            rising_q <= in_rising;
            code_q   <= masked;
            state    <= TOP_SEARCH;
          end
        end
        TOP_SEARCH: begin
          if (srch_done) begin
            if (srch_found) begin
              state <= TOP_LOAD;
            end else begin
              out_valid <= 1'b1;
              out_err   <= 1'b1;
              out_temp  <= '0;
              state     <= TOP_IDLE;
            end
          end
        end
        TOP_LOAD: begin
          base_q <= base_c;
          state  <= TOP_DIV;
        end
        TOP_DIV: begin
          if (div_done) begin
            out_valid <= 1'b1;
            out_err   <= 1'b0;
            out_temp  <= base_q + TEMP_W'(div_quo);
            state     <= TOP_IDLE;
          end
        end
        default: state <= TOP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/plc_code2temp_chk.sv
module plc_code2temp_chk #(
  parameter int ENTRIES = 35,
  parameter int TEMP_W  = 32,
  parameter int T_MIN   = -40000,
  parameter int STEP    = 5000
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_err,
  input logic [TEMP_W-1:0] out_temp
);

  localparam int LAT_MAX = 4 + $clog2(ENTRIES) + $clog2(STEP + 1);
  localparam int T_TOP   = T_MIN + (ENTRIES - 2) * STEP;

  logic [1:0]  outstanding;
  logic [15:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding <= '0;
      wait_cnt    <= '0;
    end else begin
      outstanding <= outstanding + 2'(in_valid && in_ready) - 2'(out_valid);
      if (in_valid && in_ready) wait_cnt <= '0;
      else if (outstanding != '0) wait_cnt <= wait_cnt + 16'd1;
    end
  end

  // R5 / R6: a rejected reading carries a zero temperature
  assert_err_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_temp == '0));

  assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_one_result_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (outstanding == 2'd1));

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
    outstanding <= 2'd1);

  // R3 / R4: a good result stays inside the calibrated span
  assert_temp_span_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err) |-> (($signed(out_temp) >= T_MIN) && ($signed(out_temp) <= T_TOP)));

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    (outstanding != '0) |-> (wait_cnt <= 16'(LAT_MAX)));

endmodule

bind plc_code2temp plc_code2temp_chk #(
  .ENTRIES(ENTRIES),
  .TEMP_W (TEMP_W),
  .T_MIN  (T_MIN),
  .STEP   (STEP)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_err  (out_err),
  .out_temp (out_temp)
);

// File: tb/plc_code2temp_tb.sv
module plc_code2temp_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_TB    = 10;
  localparam int CW      = 12;
  localparam int RW      = 16;
  localparam int STEP    = 5000;
  localparam int T_MIN   = -40000;
  localparam int LAT_MAX = 4 + $clog2(N_TB) + $clog2(STEP + 1);

  function automatic int fall_e(int i);
    if (i == 0) return 4095;
    return 3000 - 7 * (i - 1) - (i - 1) * (i - 1);
  endfunction

  function automatic int rise_e(int i);
    if (i == 0) return 0;
    return 200 + 3 * (i - 1) + ((i - 1) % 3);
  endfunction

  function automatic logic [N_TB*CW-1:0] pack_tab(bit rising);
    logic [N_TB*CW-1:0] t;
    t = '0;
    for (int i = 0; i < N_TB; i++)
      t[i*CW +: CW] = CW'(rising ? rise_e(i) : fall_e(i));
    return t;
  endfunction

  localparam logic [N_TB*CW-1:0] FT = pack_tab(1'b0);
  localparam logic [N_TB*CW-1:0] RT = pack_tab(1'b1);

  logic clk, rst, in_valid, in_ready, in_rising, out_valid, out_err;
  logic [RW-1:0] in_code;
  logic signed [31:0] out_temp;

  plc_code2temp #(
    .RAW_W(RW), .CODE_W(CW), .ENTRIES(N_TB), .TEMP_W(32),
    .T_MIN(T_MIN), .STEP(STEP),
    .FALL_MASK(16'h0fff), .RISE_MASK(16'h03ff),
    .FALL_TAB(FT), .RISE_TAB(RT)
  ) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_rising(in_rising), .in_code(in_code),
    .out_valid(out_valid), .out_err(out_err), .out_temp(out_temp)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ent(bit rising, int i);
    return rising ? rise_e(i) : fall_e(i);
  endfunction

  function automatic int tval(int i);
    return (i <= 1) ? T_MIN : T_MIN + (i - 1) * STEP;
  endfunction

  // Expected value straight from R2..R6.
  task automatic model(input int raw, input bit rising, output bit err, output int temp);
    int c, s;
    c = rising ? (raw & 'h3ff) : (raw & 'hfff);
    s = 0;
    for (int k = 1; k < N_TB; k++) begin
      if (rising) begin
        if (c >= ent(1, k - 1) && c < ent(1, k) && k >= 2) s = k;
        if (c >= ent(1, k - 1) && c < ent(1, k) && k == 1) s = 0;
      end else begin
        if (c >= ent(0, k) && c < ent(0, k - 1)) s = k;
      end
    end
    err  = (s == 0);
    temp = 0;
    if (!err) begin
      int d, den;
      d    = rising ? c - ent(1, s - 1) : ent(0, s - 1) - c;
      den  = rising ? ent(1, s) - ent(1, s - 1) : ent(0, s - 1) - ent(0, s);
      temp = tval(s - 1) + ((tval(s) - tval(s - 1)) * d) / den;
    end
  endtask

  task automatic convert(input int raw, input bit rising,
                         output bit got, output bit err, output int temp, output int lat);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid  = 1'b1;
    in_code   = RW'(raw);
    in_rising = rising;
    @(negedge clk);
    in_valid = 1'b0;
    got = 1'b0; err = 1'b0; temp = 0; lat = 0;
    for (int w = 0; w < 60; w++) begin
      if (out_valid) begin
        got  = 1'b1;
        err  = out_err;
        temp = int'(out_temp);
        break;
      end
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run(input int raw, input bit rising, input string tag);
    bit got, err, eerr;
    int temp, lat, etemp;
    convert(raw, rising, got, err, temp, lat);
    model(raw, rising, eerr, etemp);
    check(got, {tag, " result pulse"}, int'(got), 1);
    check(err == eerr, {tag, " error flag"}, int'(err), int'(eerr));
    check(temp == etemp, {tag, " temperature"}, temp, etemp);
    check(lat <= LAT_MAX, "R10 latency", lat, LAT_MAX);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    bit got, err;
    int temp, lat, pulses;
    rst = 1'b1; in_valid = 1'b0; in_rising = 1'b0; in_code = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    rst = 1'b0;

    // Directed corners
    run(fall_e(3), 1'b0, "R8 falling breakpoint");
    run(rise_e(4), 1'b1, "R8 rising breakpoint");
    run(fall_e(1) + 5, 1'b0, "R7 guard segment");
    run(fall_e(0) - 1, 1'b0, "R7 guard top");
    run(4095, 1'b0, "R5 sentinel code");
    run(fall_e(N_TB - 1) - 1, 1'b0, "R5 below last entry");
    run(rise_e(1) - 1, 1'b1, "R6 below first entry");
    run(rise_e(N_TB - 1), 1'b1, "R6 at last entry");
    run('hA000 | fall_e(5) + 3, 1'b0, "R2 falling upper bits");
    run('hFC00 | rise_e(2) + 1, 1'b1, "R2 rising upper bits");

    // Sweep: every falling code, with varying bits above the mask
    for (int c = 0; c < 4096; c++) begin
      int raw;
      raw = c | (((c * 37) & 'hf) << 12);
      if (c < fall_e(N_TB - 1) || c >= fall_e(0)) run(raw, 1'b0, "R5 sweep");
      else if (c >= fall_e(1))                     run(raw, 1'b0, "R7 sweep");
      else                                         run(raw, 1'b0, "R3 sweep");
    end

    // Sweep: every rising code, upper six bits varied
    for (int c = 0; c < 1024; c++) begin
      int raw;
      raw = c | (((c * 11) & 'h3f) << 10);
      if (c < rise_e(1) || c >= rise_e(N_TB - 1)) run(raw, 1'b1, "R6 sweep");
      else                                         run(raw, 1'b1, "R4 sweep");
    end

    // R9: a request held while busy is ignored; exactly one result
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_rising = 1'b0; in_code = RW'(fall_e(6) + 2);
    @(negedge clk);
    check(in_ready == 1'b0, "R9 busy after accept", int'(in_ready), 0);
    in_code = RW'(fall_e(2)); in_rising = 1'b1;
    got = 1'b0; temp = 0;
    for (int w = 0; w < 60; w++) begin
      if (out_valid) begin
        got = 1'b1; temp = int'(out_temp); err = out_err;
        in_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    begin
      bit eerr;
      int etemp;
      model(fall_e(6) + 2, 1'b0, eerr, etemp);
      check(got, "R9 first request answered", int'(got), 1);
      check(temp == etemp, "R9 busy input ignored", temp, etemp);
    end
    pulses = 0;
    for (int w = 0; w < 40; w++) begin
      @(negedge clk);
      if (out_valid) pulses++;
    end
    check(pulses == 0, "R9 single result per request", pulses, 0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule